// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, once per one-second update cycle, whether the current time of day equals a programmed alarm time. It takes the seconds, minutes and hours bytes of the running clock and three matching alarm bytes. When the update strobe arrives, it emits a one-cycle pulse that sets the update-ended status flag. In the same cycle it emits a second pulse that sets the alarm status flag, provided every alarm field matches.

Any alarm byte can be made a wildcard, which matches every value of its field. Both operands are first reduced to plain binary numbers. The data-mode input selects packed BCD or binary for every byte. In 12-hour mode the hour is also folded onto a 0 to 23 scale before comparison. Because of this, two byte patterns that name the same hour match even when their raw bits differ.

Two freeze conditions come from the surrounding clock. While the divider chain is held in reset, no update cycle happens at all. While the time is frozen for setting, update cycles still produce their pulse, but no alarm is raised.

Top module: `tod_alarm_match`

## Requirements
- R1: An update strobe sampled high while the divider is not held produces exactly one `update_set` pulse on the following cycle.
- R2: An alarm byte whose bits 7 and 6 are both 1 is a wildcard and matches any value of its field; the remaining alarm fields must still match.
- R3: With `bin_mode` low, every byte is packed BCD (tens digit in bits 7:4, units in bits 3:0), and alarm and current values compare by their decoded value.
- R4: With `bin_mode` high, every byte is a plain binary number and compares by that value.
- R5: With `hr24` low, bit 7 of an hour byte is the PM flag and the hour is taken as (value mod 12) + 12·PM. This applies to both the alarm hour and the current hour. For example, 12 AM equals hour 0 and 12 PM equals hour 12.
- R6: With all three alarm bytes set to wildcard, every update cycle raises `alarm_set`.
- R7: `alarm_set` pulses only together with `update_set`, in the same cycle, and only when all three fields match.
- R8: While `div_hold` is high, a strobe produces neither `update_set` nor `alarm_set`.
- R9: While `time_frozen` is high, a strobe still produces `update_set` but never `alarm_set`.
- R10: During reset and on the first cycle after it, both outputs are low.
- R11: Without a strobe, both outputs stay low; each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_stb | input | 1 | One-cycle update-cycle strobe |
| div_hold | input | 1 | Divider chain held in reset |
| time_frozen | input | 1 | Time frozen for setting |
| bin_mode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hr | input | 8 | Current hours |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hr | input | 8 | Alarm hours |
| alarm_set | output | 1 | Alarm-flag set pulse |
| update_set | output | 1 | Update-ended-flag set pulse |

## Verification
The update-ended pulse and the alarm pulse coincide whenever a strobe finds a matching time. The bench provokes this with exact matches, mixed wildcards, all-wildcard runs of back-to-back strobes, and hour patterns that match only after 12-hour folding. It then checks, on every cycle, that both pulses appear together and that neither appears alone when it should not. It also separates the two pulses: the time-frozen case must give the update pulse without the alarm pulse, and the divider-hold case must give neither.

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_stb,
  input  logic         div_hold,
  input  logic         time_frozen,
  input  logic         bin_mode,
  input  logic         hr24,
  input  logic [W-1:0] now_sec,
  input  logic [W-1:0] now_min,
  input  logic [W-1:0] now_hr,
  input  logic [W-1:0] alm_sec,
  input  logic [W-1:0] alm_min,
  input  logic [W-1:0] alm_hr,
  output logic         alarm_set,
  output logic         update_set
);

  localparam int NIB = W / 2;

  function automatic logic [W-1:0] to_bin(input logic [W-1:0] v, input logic bin);
    logic [W-1:0] tens, ones;
    tens = {{(W-NIB){1'b0}}, v[W-1:NIB]};
    ones = {{(W-NIB){1'b0}}, v[NIB-1:0]};
    return bin ? v : W'(tens * W'(10) + ones);
  endfunction

  function automatic logic [W-1:0] hour_norm(input logic [W-1:0] v, input logic bin,
                                             input logic h24);
    logic [W-1:0] h;
    if (h24) return to_bin(v, bin);
    h = to_bin({1'b0, v[W-2:0]}, bin) % W'(12);
    if (v[W-1]) h = h + W'(12);
    return h;
  endfunction

  logic wild_s, wild_m, wild_h;
  logic hit_s, hit_m, hit_h;
  logic run_upd, hit_all;

  assign wild_s = &alm_sec[W-1:W-2];
  assign wild_m = &alm_min[W-1:W-2];
  assign wild_h = &alm_hr[W-1:W-2];

  assign hit_s = wild_s || (to_bin(alm_sec, bin_mode) == to_bin(now_sec, bin_mode));
  assign hit_m = wild_m || (to_bin(alm_min, bin_mode) == to_bin(now_min, bin_mode));
  assign hit_h = wild_h ||
                 (hour_norm(alm_hr, bin_mode, hr24) == hour_norm(now_hr, bin_mode, hr24));

  assign run_upd = upd_stb && !div_hold;
  assign hit_all = hit_s && hit_m && hit_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      update_set <= 1'b0;
      alarm_set  <= 1'b0;
    end else begin
      update_set <= run_upd;
      alarm_set  <= run_upd && !time_frozen && hit_all;
    end
  end

endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       upd_stb,
  input logic       div_hold,
  input logic       time_frozen,
  input logic [7:0] alm_sec,
  input logic [7:0] alm_min,
  input logic [7:0] alm_hr,
  input logic       alarm_set,
  input logic       update_set
);

  // R1
  update_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !div_hold) |=> update_set);

  // R11
  no_stray_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> (!update_set && !alarm_set));

  // R7
  alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_set |-> update_set);

  // R8
  hold_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> (!update_set && !alarm_set));

  // R9
  frozen_blocks_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_frozen |=> !alarm_set);

  // R6
  all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !div_hold && !time_frozen && (&alm_sec[7:6]) && (&alm_min[7:6])
     && (&alm_hr[7:6])) |=> alarm_set);

endmodule

bind tod_alarm_match tod_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .div_hold(div_hold),
  .time_frozen(time_frozen), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
  .alarm_set(alarm_set), .update_set(update_set)
);

// File: tb/sim_tod_alarm_match.sv
`timescale 1ns/1ps
module sim_tod_alarm_match;
  logic clk = 1'b0;
  logic rst_n;
  logic upd_stb = 0, div_hold = 0, time_frozen = 0, bin_mode = 0, hr24 = 1;
  logic [7:0] now_sec = 0, now_min = 0, now_hr = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
  logic alarm_set, update_set;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit exp_alarm = 0, exp_upd = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  tod_alarm_match u0 (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .div_hold(div_hold),
    .time_frozen(time_frozen), .bin_mode(bin_mode), .hr24(hr24),
    .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .alarm_set(alarm_set), .update_set(update_set)
  );

  function automatic int dec(int b, bit bin);
    return bin ? b : ((b >> 4) * 10 + (b & 15));
  endfunction

  function automatic int hr_val(int b, bit bin, bit h24);
    if (h24) return dec(b, bin);
    return (dec(b & 127, bin) % 12) + (((b & 128) != 0) ? 12 : 0);
  endfunction

  function automatic bit is_wild(int b);
    return (b & 192) == 192;
  endfunction

  always @(posedge clk) begin
    if (rst_n !== 1'b1) begin
      exp_upd = 0;
      exp_alarm = 0;
    end else begin
      bit m;
      m = (is_wild(alm_sec) || dec(alm_sec, bin_mode) == dec(now_sec, bin_mode)) &&
          (is_wild(alm_min) || dec(alm_min, bin_mode) == dec(now_min, bin_mode)) &&
          (is_wild(alm_hr)  || hr_val(alm_hr, bin_mode, hr24) == hr_val(now_hr, bin_mode, hr24));
      exp_upd = upd_stb && !div_hold;
      exp_alarm = exp_upd && !time_frozen && m;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (update_set !== exp_upd) begin
        mismatched++;
        $display("FAIL %s update_set actual=%b expected=%b t=%0t", cur_req, update_set, exp_upd, $time);
      end
      compared++;
      if (alarm_set !== exp_alarm) begin
        mismatched++;
        $display("FAIL %s alarm_set actual=%b expected=%b t=%0t", cur_req, alarm_set, exp_alarm, $time);
      end
    end
  end

  task automatic set_time(input logic [7:0] s, m, h, as, am, ah);
    now_sec = s; now_min = m; now_hr = h;
    alm_sec = as; alm_min = am; alm_hr = ah;
  endtask

  task automatic pulse(input string req);
    @(negedge clk);
    cur_req = req;
    upd_stb = 1;
    @(negedge clk);
    upd_stb = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4 binary exact match, then seconds differ
    bin_mode = 1; hr24 = 1;
    set_time(8'd30, 8'd20, 8'd10, 8'd30, 8'd20, 8'd10); pulse("R4");
    set_time(8'd30, 8'd20, 8'd10, 8'd31, 8'd20, 8'd10); pulse("R4");
    // R1 update without alarm
    pulse("R1");
    // R3 BCD match and mismatch
    bin_mode = 0;
    set_time(8'h59, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23); pulse("R3");
    set_time(8'h58, 8'h59, 8'h23, 8'h59, 8'h59, 8'h23); pulse("R3");
    // R5 12-hour folding
    hr24 = 0;
    set_time(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h92); pulse("R5");
    set_time(8'h00, 8'h00, 8'h92, 8'h00, 8'h00, 8'h12); pulse("R5");
    set_time(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00); pulse("R5");
    bin_mode = 1;
    set_time(8'd5, 8'd6, 8'h8C, 8'd5, 8'd6, 8'h80); pulse("R5");
    set_time(8'd5, 8'd6, 8'h0C, 8'd5, 8'd6, 8'h8C); pulse("R5");
    // R5 24-hour: 0 and 12 differ
    hr24 = 1;
    set_time(8'd5, 8'd6, 8'd0, 8'd5, 8'd6, 8'd12); pulse("R5");
    // R2 partial wildcards
    bin_mode = 0;
    set_time(8'h17, 8'h44, 8'h08, 8'hFF, 8'hC0, 8'h08); pulse("R2");
    set_time(8'h17, 8'h44, 8'h09, 8'hFF, 8'hC0, 8'h08); pulse("R2");
    set_time(8'h17, 8'h44, 8'h09, 8'hC3, 8'h44, 8'hC7); pulse("R2");
    set_time(8'h17, 8'h44, 8'h09, 8'h83, 8'h44, 8'hC7); pulse("R2");
    // R6 all wildcards, back-to-back strobes
    set_time(8'h01, 8'h02, 8'h03, 8'hC0, 8'hD5, 8'hFF);
    @(negedge clk); cur_req = "R6"; upd_stb = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      now_sec = now_sec + 8'h01;
    end
    upd_stb = 0;
    @(negedge clk);
    // R9 frozen: update only
    time_frozen = 1; pulse("R9");
    time_frozen = 0;
    // R8 divider held: nothing
    div_hold = 1; pulse("R8");
    div_hold = 0;
    // R7 coincident pulses after release
    pulse("R7");
    // R11 idle
    cur_req = "R11";
    repeat (5) @(negedge clk);
    // R10 reset mid-run
    cur_req = "R10";
    upd_stb = 1;
    rst_n = 0;
    repeat (2) @(negedge clk);
    upd_stb = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule